// File: doc/BRIEF.md
# Addressable Latch with Demultiplex Mode

This block keeps a small bank of single-bit outputs that can be written one at a time, selected by a binary address. Two active-low controls, `enable_n` and `clear_n`, choose one of four modes. In write mode the addressed output takes the data bit and the other outputs keep their values. In hold mode nothing changes. In decode mode the addressed output takes the data bit and all other outputs go low. In clear mode all outputs go low.

The block is fully synchronous. The controls, address and data are sampled on each rising clock edge, and the outputs show the result on that same edge. The same bank can therefore act as a set of individually settable control flags or as a registered one-of-N demultiplexer.

In write mode, a jump of more than one address bit between two consecutive cycles could select the wrong cell if the address lines were slewing. A monitor therefore compares each address with the one from the cycle before and raises a sticky error flag on such a jump. When the `GUARD` parameter is 1, the write of that cycle is also dropped.

Top module: `alat_addr_latch`

## Requirements
- R1: With `clear_n`=1 and `enable_n`=0 (write mode), the output whose index equals `addr` takes `data_in` and every other output keeps its value, unless R9 drops the write.
- R2: With `clear_n`=1 and `enable_n`=1 (hold mode), every output keeps its value whatever `addr` and `data_in` are.
- R3: With `clear_n`=0 and `enable_n`=0 (decode mode), output `addr` takes `data_in` and every other output becomes 0.
- R4: With `clear_n`=0 and `enable_n`=1 (clear mode), all outputs become 0 whatever `addr` and `data_in` are.
- R5: Inputs are sampled on the rising clock edge, and `q` shows the new value directly after that edge.
- R6: A rising edge with `rst`=1 sets `q` to all zeros and `addr_err` to 0. The cycle sampled at that edge is not used as a previous address for R7.
- R7: `addr_err` becomes 1 after an edge in write mode at which `addr` differs in two or more bit positions from the `addr` sampled at the previous edge. The previous edge must lie after reset. Once set, the flag stays 1 while `clear_n` stays 1.
- R8: An edge with `clear_n`=0 (decode or clear mode) sets `addr_err` to 0.
- R9: When `GUARD`=1, a write-mode edge that sets the hazard condition of R7 leaves `q` unchanged. When `GUARD`=0, the write takes place as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Index of the output being written or decoded |
| data_in | input | 1 | Data bit for the addressed output |
| enable_n | input | 1 | Active-low enable; part of the mode select |
| clear_n | input | 1 | Active-low clear; part of the mode select and clears the error flag |
| q | output | 2**ADDR_W | Output bank |
| addr_err | output | 1 | Sticky flag for a multi-bit address jump in write mode |

## Verification
The bench builds two copies with the default 3-bit address, which gives eight outputs. One copy has `GUARD`=1 and the other `GUARD`=0, and both receive the same stimulus. Running them side by side shows, at the same edge, a hazardous write being dropped in one copy and taking effect in the other, while the error flag behaves the same in both. With eight outputs, the bench can visit every address in each mode and walk a Gray-code address order, so write mode can be exercised both with and without a hazard.

// File: rtl/alat_pkg.sv
package alat_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR = 2'd3
  } alat_mode_e;

  // clear_n high: write (enable_n low) or hold; clear_n low: decode or clear
  function automatic alat_mode_e mode_of(input logic clear_n, input logic enable_n);
    alat_mode_e m;
    case ({clear_n, enable_n})
      2'b10:   m = MODE_WRITE;
      2'b11:   m = MODE_HOLD;
      2'b00:   m = MODE_DECODE;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alat_mode_decode.sv
module alat_mode_decode
  import alat_pkg::*;
(
  input  logic       enable_n,
  input  logic       clear_n,
  output alat_mode_e mode,
  output logic       is_write
);

  always_comb begin
    mode     = mode_of(clear_n, enable_n);
    is_write = (mode == MODE_WRITE);
  end

endmodule

// File: rtl/alat_hazard_mon.sv
module alat_hazard_mon #(
  parameter int ADDR_W = 3,
  parameter bit GUARD  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              clear_n,
  output logic              hazard,
  output logic              drop_write,
  output logic              err_q
);

  logic [ADDR_W-1:0] prev_addr;
  logic              prev_vld;
  int unsigned       flips;

  function automatic int unsigned flip_count(input logic [ADDR_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < ADDR_W; i++) begin
      n += {31'd0, v[i]};
    end
    return n;
  endfunction

  always_comb begin
    flips      = flip_count(addr ^ prev_addr);
    hazard     = prev_vld && is_write && (flips > 1);
    drop_write = GUARD && hazard;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr <= '0;
      prev_vld  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      prev_addr <= addr;
      prev_vld  <= 1'b1;
      if (!clear_n) begin
        err_q <= 1'b0;
      end else if (hazard) begin
        err_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/alat_cell_bank.sv
module alat_cell_bank
  import alat_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               data_in,
  input  alat_mode_e         mode,
  input  logic               drop_write,
  output logic [NUM_OUT-1:0] q
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    logic sel;
    assign sel = (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
      end else begin
        case (mode)
          MODE_WRITE:  if (sel && !drop_write) q[i] <= data_in;
          MODE_HOLD:   q[i] <= q[i];
          MODE_DECODE: q[i] <= sel & data_in;
          default:     q[i] <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/alat_addr_latch.sv
module alat_addr_latch
  import alat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter bit GUARD  = 1'b1,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               data_in,
  input  logic               enable_n,
  input  logic               clear_n,
  output logic [NUM_OUT-1:0] q,
  output logic               addr_err
);

  alat_mode_e mode_w;
  logic       is_write_w;
  logic       hazard_w;
  logic       drop_w;

  alat_mode_decode u_mode (
    .enable_n (enable_n),
    .clear_n  (clear_n),
    .mode     (mode_w),
    .is_write (is_write_w)
  );

  alat_hazard_mon #(.ADDR_W(ADDR_W), .GUARD(GUARD)) u_haz (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .is_write   (is_write_w),
    .clear_n    (clear_n),
    .hazard     (hazard_w),
    .drop_write (drop_w),
    .err_q      (addr_err)
  );

  alat_cell_bank #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .data_in    (data_in),
    .mode       (mode_w),
    .drop_write (drop_w),
    .q          (q)
  );

endmodule

// File: rtl/alat_addr_latch_chk.sv
module alat_addr_latch_chk #(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               data_in,
  input logic               enable_n,
  input logic               clear_n,
  input logic [NUM_OUT-1:0] q,
  input logic               addr_err,
  input logic               hazard,
  input logic               drop
);

  // R1: only the addressed cell may change in write mode
  a_r1_write_one_cell: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !enable_n && !drop) |=>
      ((((q ^ $past(q)) & ~(NUM_OUT'(1) << $past(addr))) == '0) && (q[$past(addr)] == $past(data_in))));

  // R2
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (clear_n && enable_n) |=> $stable(q));

  // R3
  a_r3_decode_onehot: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && !enable_n) |=> ($countones(q) <= 1) && (q[$past(addr)] == $past(data_in)));

  // R4
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && enable_n) |=> (q == '0));

  // R6
  a_r6_reset_state: assert property (@(posedge clk)
    rst |=> (q == '0) && !addr_err);

  // R7
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    ((addr_err || hazard) && clear_n) |=> addr_err);

  // R8
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> !addr_err);

  // R9
  a_r9_drop_holds: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(q));

endmodule

bind alat_addr_latch alat_addr_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .data_in  (data_in),
  .enable_n (enable_n),
  .clear_n  (clear_n),
  .q        (q),
  .addr_err (addr_err),
  .hazard   (hazard_w),
  .drop     (drop_w)
);

// File: tb/tb_alat_addr_latch.sv
module tb_alat_addr_latch;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       data_in = 1'b0;
  logic       enable_n = 1'b1;
  logic       clear_n = 1'b1;
  logic [7:0] q_g, q_p;
  logic       err_g, err_p;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_g, m_p;
  bit         m_err;
  logic [2:0] m_prev;
  bit         m_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  alat_addr_latch #(.ADDR_W(3), .GUARD(1'b1)) dut (
    .clk(clk), .rst(rst), .addr(addr), .data_in(data_in),
    .enable_n(enable_n), .clear_n(clear_n), .q(q_g), .addr_err(err_g));

  alat_addr_latch #(.ADDR_W(3), .GUARD(1'b0)) dut_pass (
    .clk(clk), .rst(rst), .addr(addr), .data_in(data_in),
    .enable_n(enable_n), .clear_n(clear_n), .q(q_p), .addr_err(err_p));

  task automatic check(input string tag, input string what, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_edge(input bit r, input logic [2:0] a, input bit d, input bit en_n, input bit clr_n);
    bit hz;
    if (r) begin
      m_g = '0; m_p = '0; m_err = 0; m_prev = '0; m_vld = 0;
      return;
    end
    hz = m_vld && clr_n && !en_n && ($countones(a ^ m_prev) >= 2);
    if (clr_n && !en_n) begin
      m_p[a] = d;
      if (!hz) m_g[a] = d;
    end else if (!clr_n && !en_n) begin
      m_g = '0; m_p = '0; m_g[a] = d; m_p[a] = d;
    end else if (!clr_n) begin
      m_g = '0; m_p = '0;
    end
    if (!clr_n) m_err = 0;
    else if (hz) m_err = 1;
    m_prev = a; m_vld = 1;
  endfunction

  // one clock: drive at negedge, model at posedge, compare just after
  task automatic step(input bit r, input logic [2:0] a, input bit d, input bit en_n, input bit clr_n, input string tag);
    @(negedge clk);
    rst = r; addr = a; data_in = d; enable_n = en_n; clear_n = clr_n;
    @(posedge clk);
    model_edge(r, a, d, en_n, clr_n);
    #1;
    check(tag, "q guarded", {1'b0, q_g}, {1'b0, m_g});
    check(tag, "q pass", {1'b0, q_p}, {1'b0, m_p});
    check(tag, "addr_err", {8'd0, err_g}, {8'd0, m_err});
    check(tag, "addr_err pass", {8'd0, err_p}, {8'd0, m_err});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] gray [8] = '{3'd0, 3'd1, 3'd3, 3'd2, 3'd6, 3'd7, 3'd5, 3'd4};
    // R6: reset state
    step(1, 3'd7, 1, 0, 1, "R6");
    step(1, 3'd0, 0, 1, 1, "R6");
    // R6: first cycle after reset has no previous address, jump is harmless
    step(0, 3'd7, 1, 0, 1, "R6");
    check("R6", "no flag after reset", {8'd0, err_g}, 9'd0);
    // R1/R5: write every cell along Gray order (single-bit steps)
    step(0, 3'd5, 0, 0, 1, "R1");
    step(0, 3'd4, 1, 0, 1, "R1");
    for (int i = 0; i < 8; i++) step(0, gray[i], gray[i][0], 0, 1, "R1");
    check("R1", "gray pattern", {1'b0, q_g}, 9'h0AA);
    // R2: hold with arbitrary addr/data
    for (int i = 0; i < 8; i++) step(0, 3'(i), ~gray[i][0], 1, 1, "R2");
    check("R2", "hold kept", {1'b0, q_g}, 9'h0AA);
    // R3: decode each address with both data values
    for (int i = 0; i < 8; i++) begin
      step(0, 3'(i), 1, 0, 0, "R3");
      check("R3", "decode one-hot", {1'b0, q_g}, {1'b0, 8'(1) << i});
      step(0, 3'(i), 0, 0, 0, "R3");
    end
    // R4: clear mode after filling
    step(0, 3'd2, 1, 0, 0, "R3");
    step(0, 3'd2, 1, 0, 1, "R1");
    step(0, 3'd3, 1, 0, 1, "R1");
    step(0, 3'd6, 1, 1, 0, "R4");
    check("R4", "clear all", {1'b0, q_p}, 9'd0);
    // R7/R9: hazard jump 0 -> 3 in write mode
    step(0, 3'd0, 0, 1, 1, "R2");
    step(0, 3'd3, 1, 0, 1, "R7");
    check("R9", "guard dropped", {1'b0, q_g}, 9'd0);
    check("R9", "pass wrote", {1'b0, q_p}, 9'h008);
    check("R7", "flag set", {8'd0, err_g}, 9'd1);
    // R7: sticky through hold and legal writes
    step(0, 3'd5, 0, 1, 1, "R7");
    step(0, 3'd4, 1, 0, 1, "R7");
    check("R7", "flag sticky", {8'd0, err_p}, 9'd1);
    // R8: decode clears flag; clear mode too
    step(0, 3'd4, 1, 0, 0, "R8");
    check("R8", "flag cleared", {8'd0, err_g}, 9'd0);
    step(0, 3'd0, 1, 0, 1, "R7");
    step(0, 3'd7, 1, 0, 1, "R7");
    step(0, 3'd7, 0, 1, 0, "R8");
    check("R8", "clear mode clears flag", {8'd0, err_g}, 9'd0);
    // R6: reset mid-run clears q and flag
    step(0, 3'd1, 1, 0, 1, "R1");
    step(0, 3'd6, 1, 0, 1, "R7");
    step(1, 3'd6, 1, 0, 1, "R6");
    check("R6", "reset clears", {err_g, q_p}, 9'd0);
    // mixed random traffic, model compared every cycle (R1 R2 R3 R4 R5 R7 R8 R9)
    for (int i = 0; i < 600; i++) begin
      int unsigned pick = $urandom_range(0, 9);
      bit en_n = (pick >= 4 && pick < 7) || pick == 9;
      bit clr_n = pick < 7;
      step(0, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), en_n, clr_n, "R5");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule